// File: doc/BRIEF.md
# Video Port Debug-Suspend Controller

This block decides when a video capture or display port may issue DMA events while a debug halt is requested. It holds a small control word with a free-run bit and a port-enable bit. It watches a field-end strobe and the parity of the field that is ending, both supplied by the port's timing counters. The timing counters themselves keep running throughout.

When free-run is off and a suspend request arrives, the field in progress is allowed to finish. The block then stops DMA events and interrupts, and selects default display data. The port clocks stay enabled. When the request is withdrawn, the block waits for the start of a field whose parity is opposite to the last field it completed. Only then does it re-enable events, so buffer pointers line up with the point where transfers stopped.

Top module: `vp_susp_ctl`

## Requirements
- R1: The control word has free-run at bit 0, a hardwired-zero soft bit at bit 1 and port-enable at bit 2. A write updates bits 0 and 2 only. Every other bit, including bit 1, always reads 0.
- R2: After reset the control word reads 0x00000001. With that value, port_clk_en, dma_evt_en and irq_en are all 0.
- R3: While free-run is 1, a suspend request has no effect: dma_evt_en and irq_en keep following port-enable.
- R4: With free-run 0, a suspend request moves the block into a draining state, and events remain enabled during it. In the cycle after a clock edge that samples fld_end high with suspend still requested, dma_evt_en and irq_en fall to 0. At that edge the block records fld_odd as the halt parity.
- R5: While halted or waiting to resume, dflt_data_sel is 1 and port_clk_en still equals port-enable.
- R6: After suspend is released, events return in the cycle after an edge that samples fld_end high with fld_odd equal to the recorded halt parity. That edge is the start of a field of the opposite parity. Field ends of the other parity leave the block halted.
- R7: If suspend drops while draining and before any field end, the block returns to running. dma_evt_en never falls.
- R8: Setting free-run to 1 while draining, halted or waiting does not return the block to running at once. A draining block returns at the next field end. A halted block returns only at the parity-matched field end of R6.
- R9: When port-enable is 0, port_clk_en, dma_evt_en and irq_en are 0.
- R10: If suspend is requested again while waiting to resume, the block goes back to halted and keeps the recorded parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| susp_req | input | 1 | Debug-halt suspend request |
| fld_end | input | 1 | One-cycle strobe at the end of each field |
| fld_odd | input | 1 | Parity of the field ending when fld_end is high (1 = odd) |
| dma_evt_en | output | 1 | DMA event generation enable |
| irq_en | output | 1 | Port interrupt enable |
| dflt_data_sel | output | 1 | Select default data in the active window |
| port_clk_en | output | 1 | Enable for the port clocks |

## Verification
The assertions assume that fld_end is a single-cycle strobe. They also assume that fld_odd is valid whenever fld_end is high, and that field parity alternates from one field end to the next, as real timing counters produce it. The random stimulus keeps its own field parity, which flips on every field end it issues. The suspend request, register writes and field-end spacing are random. Directed segments break the alternation on purpose only to show that a field end of the wrong parity keeps the block halted.

// File: rtl/vp_susp_pkg.sv
package vp_susp_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_HALTED = 2'd2,
      ST_WAIT   = 2'd3
   } vps_state_e;

   function automatic logic events_on(input vps_state_e st);
      return (st == ST_RUN) || (st == ST_DRAIN);
   endfunction

endpackage

// File: rtl/vp_susp_regs.sv
module vp_susp_regs #(
   parameter int   DATA_W   = 32,
   parameter int   FREE_BIT = 0,
   parameter int   SOFT_BIT = 1,
   parameter int   EN_BIT   = 2,
   parameter logic FREE_RST = 1'b1,
   parameter logic EN_RST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              free_o,
   output logic              en_o
);

   localparam int MAX_BIT = (FREE_BIT > EN_BIT) ? FREE_BIT : EN_BIT;

   if (MAX_BIT >= DATA_W || SOFT_BIT >= DATA_W) begin : g_bad_width
      $error("vp_susp_regs: field position beyond DATA_W");
   end
   if (FREE_BIT == EN_BIT || FREE_BIT == SOFT_BIT || EN_BIT == SOFT_BIT) begin : g_bad_pos
      $error("vp_susp_regs: control fields overlap");
   end

   logic free_q;
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= FREE_RST;
         en_q   <= EN_RST;
      end else if (wr) begin
         free_q <= wdata[FREE_BIT];
         en_q   <= wdata[EN_BIT];
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[FREE_BIT] = free_q;
      rdata[EN_BIT]   = en_q;
   end

   assign free_o = free_q;
   assign en_o   = en_q;

   AST_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (free_o == $past(wdata[FREE_BIT]))); // R1
   AST_WR_EN: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (en_o == $past(wdata[EN_BIT]))); // R1
   AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(rdata)); // R1

endmodule

// File: rtl/vp_susp_fsm.sv
module vp_susp_fsm
   import vp_susp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       free,
   input  logic       susp_req,
   input  logic       fld_end,
   input  logic       fld_odd,
   output vps_state_e state_o,
   output logic       halt_par_o
);

   vps_state_e state_q, state_d;
   logic       par_q, par_d;
   logic       eff_req;

   assign eff_req = susp_req & ~free;

   always_comb begin
      state_d = state_q;
      par_d   = par_q;
      unique case (state_q)
         ST_RUN: begin
            if (eff_req) state_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (fld_end) begin
               if (eff_req) begin
                  state_d = ST_HALTED;
                  par_d   = fld_odd;
               end else begin
                  state_d = ST_RUN;
               end
            end else if (!susp_req) begin
               state_d = ST_RUN;
            end
         end
         ST_HALTED: begin
            if (!eff_req) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (eff_req)                          state_d = ST_HALTED;
            else if (fld_end && fld_odd == par_q) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         par_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         par_q   <= par_d;
      end
   end

   assign state_o    = state_q;
   assign halt_par_o = par_q;

   AST_FREE_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && free) |=> (state_q == ST_RUN)); // R3
   AST_HALT_AT_FIELD_END: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALTED && $past(state_q) == ST_DRAIN) |-> $past(fld_end)); // R4
   AST_RESUME_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && $past(state_q) == ST_WAIT)
         |-> ($past(fld_end) && $past(fld_odd) == par_q)); // R6
   AST_CANCEL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN && !susp_req && !fld_end) |=> (state_q == ST_RUN)); // R7
   AST_PAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && eff_req) |=> (state_q == ST_HALTED && $stable(par_q))); // R10

endmodule

// File: rtl/vp_susp_outs.sv
module vp_susp_outs
   import vp_susp_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  vps_state_e state,
   input  logic       port_en,
   output logic       dma_evt_en,
   output logic       irq_en,
   output logic       dflt_data_sel,
   output logic       port_clk_en
);

   logic ev_c, dflt_c;

   assign ev_c   = port_en & events_on(state);
   assign dflt_c = ~events_on(state);

   if (OUT_REG) begin : g_reg
      logic ev_q, dflt_q, clk_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ev_q   <= 1'b0;
            dflt_q <= 1'b0;
            clk_q  <= 1'b0;
         end else begin
            ev_q   <= ev_c;
            dflt_q <= dflt_c;
            clk_q  <= port_en;
         end
      end
      assign dma_evt_en    = ev_q;
      assign irq_en        = ev_q;
      assign dflt_data_sel = dflt_q;
      assign port_clk_en   = clk_q;
   end else begin : g_comb
      assign dma_evt_en    = ev_c;
      assign irq_en        = ev_c;
      assign dflt_data_sel = dflt_c;
      assign port_clk_en   = port_en;
   end

endmodule

// File: rtl/vp_susp_ctl.sv
module vp_susp_ctl
   import vp_susp_pkg::*;
#(
   parameter int   DATA_W   = 32,
   parameter int   FREE_BIT = 0,
   parameter int   SOFT_BIT = 1,
   parameter int   EN_BIT   = 2,
   parameter logic FREE_RST = 1'b1,
   parameter logic EN_RST   = 1'b0,
   parameter bit   OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              susp_req,
   input  logic              fld_end,
   input  logic              fld_odd,
   output logic              dma_evt_en,
   output logic              irq_en,
   output logic              dflt_data_sel,
   output logic              port_clk_en
);

   logic       free_w;
   logic       en_w;
   logic       par_w;
   vps_state_e st_w;

   vp_susp_regs #(
      .DATA_W  (DATA_W),
      .FREE_BIT(FREE_BIT),
      .SOFT_BIT(SOFT_BIT),
      .EN_BIT  (EN_BIT),
      .FREE_RST(FREE_RST),
      .EN_RST  (EN_RST)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .free_o(free_w),
      .en_o  (en_w)
   );

   vp_susp_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .free      (free_w),
      .susp_req  (susp_req),
      .fld_end   (fld_end),
      .fld_odd   (fld_odd),
      .state_o   (st_w),
      .halt_par_o(par_w)
   );

   vp_susp_outs #(.OUT_REG(OUT_REG)) u_outs (
      .clk          (clk),
      .rst_n        (rst_n),
      .state        (st_w),
      .port_en      (en_w),
      .dma_evt_en   (dma_evt_en),
      .irq_en       (irq_en),
      .dflt_data_sel(dflt_data_sel),
      .port_clk_en  (port_clk_en)
   );

   if (!OUT_REG) begin : g_chk
      AST_HALT_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
         (dflt_data_sel && en_w) |-> (port_clk_en && !dma_evt_en)); // R5
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_rdata[EN_BIT] |-> (!port_clk_en && !dma_evt_en && !irq_en)); // R9
   end

endmodule

// File: tb/sim_vp_susp_ctl.sv
`timescale 1ns/1ps
module sim_vp_susp_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        susp_req = 1'b0;
   logic        fld_end = 1'b0;
   logic        fld_odd = 1'b0;
   logic        dma_evt_en, irq_en, dflt_data_sel, port_clk_en;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state: 0 run, 1 drain, 2 halted, 3 waiting
   int   m_st   = 0;
   logic m_par  = 1'b0;
   logic m_free = 1'b1;
   logic m_en   = 1'b0;
   logic gen_par = 1'b0;

   always #5 clk = ~clk;

   vp_susp_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .susp_req(susp_req), .fld_end(fld_end),
      .fld_odd(fld_odd), .dma_evt_en(dma_evt_en), .irq_en(irq_en),
      .dflt_data_sel(dflt_data_sel), .port_clk_en(port_clk_en)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic exp_ev();
      return m_en & (m_st < 2);
   endfunction

   task automatic check_all(input string tag);
      chk({31'b0, dma_evt_en},    {31'b0, exp_ev()},      {tag, " dma_evt_en"});
      chk({31'b0, irq_en},        {31'b0, exp_ev()},      {tag, " irq_en"});
      chk({31'b0, dflt_data_sel}, {31'b0, m_st >= 2},     {tag, " dflt_data_sel"});
      chk({31'b0, port_clk_en},   {31'b0, m_en},          {tag, " port_clk_en"});
      chk(cfg_rdata, {29'b0, m_en, 1'b0, m_free},         {tag, " cfg_rdata"});
   endtask

   task automatic step(input logic wr, input logic [31:0] wd, input logic s,
                       input logic fe, input logic od, input string tag);
      logic eff;
      cfg_wr = wr; cfg_wdata = wd; susp_req = s; fld_end = fe; fld_odd = od;
      @(posedge clk);
      eff = s & ~m_free;
      case (m_st)
         0: if (eff) m_st = 1;
         1: if (fe) begin
               if (eff) begin m_st = 2; m_par = od; end else m_st = 0;
            end else if (!s) m_st = 0;
         2: if (!eff) m_st = 3;
         default: if (eff) m_st = 2; else if (fe && od == m_par) m_st = 0;
      endcase
      if (wr) begin m_free = wd[0]; m_en = wd[2]; end
      #1;
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      check_all("R2 reset");
      chk(cfg_rdata, 32'h1, "R2 reset word");

      // R1: all ones -> only bits 0 and 2 stick
      step(1, 32'hFFFF_FFFF, 0, 0, 0, "R1 write ones");
      chk(cfg_rdata, 32'h5, "R1 reserved and soft read 0");
      // R3: free=1, suspend with field end is ignored
      step(0, 0, 1, 1, 1, "R3 free ignores");
      step(0, 0, 1, 0, 0, "R3 free ignores");
      chk({31'b0, dma_evt_en}, 32'h1, "R3 dma stays on");
      step(1, 32'h4, 0, 0, 0, "R1 free off");

      // R4: drain then halt at field end (odd)
      step(0, 0, 1, 0, 0, "R4 drain");
      step(0, 0, 1, 0, 0, "R4 drain");
      chk({31'b0, dma_evt_en}, 32'h1, "R4 events during drain");
      step(0, 0, 1, 1, 1, "R4 halt");
      chk({31'b0, dma_evt_en}, 32'h0, "R4 halted no events");
      chk({31'b0, port_clk_en}, 32'h1, "R5 clocks run");
      chk({31'b0, dflt_data_sel}, 32'h1, "R5 default data");
      // R6: release; even field end keeps halted, odd resumes
      step(0, 0, 0, 0, 0, "R6 release");
      step(0, 0, 0, 1, 0, "R6 wrong parity");
      chk({31'b0, dma_evt_en}, 32'h0, "R6 wrong parity stays off");
      step(0, 0, 0, 1, 1, "R6 resume");
      chk({31'b0, dma_evt_en}, 32'h1, "R6 resumed");

      // R7: cancel before field end
      step(0, 0, 1, 0, 0, "R7 drain");
      step(0, 0, 0, 0, 0, "R7 cancel");
      step(0, 0, 0, 1, 0, "R7 after");
      chk({31'b0, dma_evt_en}, 32'h1, "R7 never dropped");

      // R8: free set while halted (halt parity even)
      step(0, 0, 1, 0, 0, "R8 drain");
      step(0, 0, 1, 1, 0, "R8 halt");
      step(1, 32'h5, 1, 0, 0, "R8 free on");
      step(0, 0, 1, 0, 0, "R8 waiting");
      chk({31'b0, dma_evt_en}, 32'h0, "R8 not immediate");
      step(0, 0, 1, 1, 1, "R8 wrong parity");
      step(0, 0, 1, 1, 0, "R8 resume");
      chk({31'b0, dma_evt_en}, 32'h1, "R8 resumed at boundary");

      // R10: re-request while waiting
      step(1, 32'h4, 0, 0, 0, "R10 free off");
      step(0, 0, 1, 0, 0, "R10 drain");
      step(0, 0, 1, 1, 1, "R10 halt");
      step(0, 0, 0, 0, 0, "R10 wait");
      step(0, 0, 1, 1, 1, "R10 rehalt");
      chk({31'b0, dflt_data_sel}, 32'h1, "R10 back to halted");
      step(0, 0, 0, 0, 0, "R10 wait again");
      step(0, 0, 0, 1, 1, "R10 kept parity");
      chk({31'b0, dma_evt_en}, 32'h1, "R10 resumed on kept parity");

      // R9: port disabled
      step(1, 32'h1, 0, 0, 0, "R9 disable");
      chk({31'b0, port_clk_en}, 32'h0, "R9 clocks off");

      // random mix, parity alternating per field end
      begin
         logic s = 1'b0;
         for (int i = 0; i < 4000; i++) begin
            logic fe, wr;
            logic [31:0] wd;
            if ($urandom_range(0, 19) == 0) s = ~s;
            fe = ($urandom_range(0, 5) == 0);
            wr = ($urandom_range(0, 39) == 0);
            wd = $urandom;
            if ($urandom_range(0, 3) != 0) wd[2] = 1'b1;
            if ($urandom_range(0, 2) != 0) wd[0] = 1'b0;
            step(wr, wd, s, fe, gen_par, "R3 R4 R6 R7 R8 random");
            if (fe) gen_par = ~gen_par;
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule